// File: doc/BRIEF.md
# Multichannel PWM Generator with Period-Aligned Buffered Updates

This block drives sixteen pulse outputs from one free-running period counter. A shared period register sets the counter's last value. Each channel has a rising-position register and a falling-position register. In pulse mode the channel output turns on when the counter reaches the rising position and turns off when it reaches the falling position. A per-channel invert bit flips the pin. A second elaboration-time mask turns selected channels into low-ripple level outputs. A level channel adds its falling-position value into an accumulator every clock and drives its pin from the carry, so the pin toggles as fast as possible while keeping the programmed average.

A channel picked by the elaboration-time buffer mask holds a pending copy of both position registers. A single runtime bit then selects the update mode for those channels. When the bit is set, writes land in the pending copy and every buffered channel moves its pending values into use on the same clock edge, when the counter restarts. When the bit is clear, writes take effect at once. Channels without a buffer always update at once. Software reaches all registers through a zero-wait-state APB slave.

Top module: `pwm_bank`

## Requirements
- R1: APB accesses complete with no wait states (pready is 1). A write takes effect on the clock edge of its access phase (psel and penable high). Register byte addresses: 0x00 period (bits CW-1:0), 0x04 control (bit 0 = sync mode), 0x08 invert mask (bit i = channel i), 0x40+8*i rising position of channel i, 0x44+8*i falling position of channel i. A read returns the last value written to the register, and any other address reads 0.
- R2: The period counter starts at 0 after reset and steps by one each clock. On the clock after it reaches a value at or above the period register, it returns to 0.
- R3: In pulse mode a channel's state goes to 0 on the clock after the counter equals the falling position. Otherwise it goes to 1 on the clock after the counter equals the rising position, and otherwise it holds. When both positions are equal, the falling position wins.
- R4: For a buffered channel with sync mode set, a write changes only the pending copy. All buffered channels move their pending values into use on the edge where the counter returns to 0.
- R5: For a buffered channel with sync mode clear, a write is put into use on the edge of the write.
- R6: An unbuffered channel puts a write into use on the edge of the write, whatever the sync bit holds.
- R7: Each pin equals the channel state XOR its invert bit, and an invert write acts at once.
- R8: A level channel adds its falling-position value into a CW-bit accumulator each clock and drives the carry as its state. Over any 2^CW consecutive cycles with a constant value L, its pin is high in exactly L of them.
- R9: After reset all pins are 0, the period register holds all ones, and the control, invert and position registers hold 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when 1 |
| paddr | input | 8 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always 1, no wait states |
| pwm_out | output | NCH | Channel output pins |

## Verification
A cycle-accurate reference model in the bench runs alongside the design and is compared with every pin on every cycle. Random writes of the period, position, sync and invert registers make buffered channels in both modes, unbuffered channels and the level channel disagree whenever an update lands on the wrong edge. Directed patterns back this up. A short period with fixed positions yields a known duty. The same pattern with the invert bit set yields its complement. A write made in sync mode just after the counter restarts must not move the pin before the next restart, while the same write to an unbuffered channel or in the immediate mode must. Level values 0, 64 and 200 must each give an exact high count over 256 cycles.

// File: rtl/pwm_bank_pkg.sv
// Shared address map for the PWM bank register slave.
// Assumes an 8-bit byte address with word-aligned registers.
package pwm_bank_pkg;
    localparam logic [7:0] ADDR_PERIOD  = 8'h00;
    localparam logic [7:0] ADDR_CTRL    = 8'h04;
    localparam logic [7:0] ADDR_INVERT  = 8'h08;
    localparam logic [7:0] ADDR_CH_BASE = 8'h40;
    localparam int         CH_STRIDE    = 8;
endpackage

// File: rtl/pwm_regs.sv
// Register slave: decodes APB accesses and holds the global registers
// (period, sync mode, invert mask). It raises per-channel write strobes for
// the position registers and reports channel read hits to the top.
// Assumes NCH <= 16 so that the invert mask fits the low data half.
module pwm_regs
    import pwm_bank_pkg::*;
#(
    parameter int NCH = 16,
    parameter int CW  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             psel,
    input  logic             penable,
    input  logic             pwrite,
    input  logic [7:0]       paddr,
    input  logic [31:0]      pwdata,
    output logic [CW-1:0]    period,
    output logic             sync_en,
    output logic [NCH-1:0]   inv,
    output logic [NCH-1:0]   on_we,
    output logic [NCH-1:0]   off_we,
    output logic             ch_hit,
    output logic [$clog2(NCH)-1:0] ch_idx,
    output logic             ch_field,
    output logic [31:0]      glb_rdata
);
    localparam int IDXW = $clog2(NCH);

    logic       wr_en;
    logic [7:0] ch_off;
    logic       unused_hi;

    assign wr_en     = psel && penable && pwrite;
    assign ch_off    = paddr - ADDR_CH_BASE;
    assign ch_hit    = (paddr >= ADDR_CH_BASE) && (int'(ch_off) < NCH * CH_STRIDE)
                       && (paddr[1:0] == 2'b00);
    assign ch_idx    = ch_off[IDXW+2:3];
    assign ch_field  = ch_off[2];
    assign unused_hi = ^pwdata[31:NCH];

    // Demultiplex a channel write into the rising/falling strobes.
    always_comb begin
        on_we  = '0;
        off_we = '0;
        for (int i = 0; i < NCH; i++) begin
            if (wr_en && ch_hit && (int'(ch_idx) == i)) begin
                on_we[i]  = !ch_field;
                off_we[i] = ch_field;
            end
        end
    end

    // Global registers, written in the APB access phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period  <= '1;
            sync_en <= 1'b0;
            inv     <= '0;
        end else if (wr_en) begin
            case (paddr)
                ADDR_PERIOD: period  <= pwdata[CW-1:0];
                ADDR_CTRL:   sync_en <= pwdata[0];
                ADDR_INVERT: inv     <= pwdata[NCH-1:0];
                default: ;
            endcase
        end
    end

    // Read data for the global registers; zero elsewhere.
    always_comb begin
        case (paddr)
            ADDR_PERIOD: glb_rdata = {{(32-CW){1'b0}}, period};
            ADDR_CTRL:   glb_rdata = {31'b0, sync_en};
            ADDR_INVERT: glb_rdata = {{(32-NCH){1'b0}}, inv};
            default:     glb_rdata = '0;
        endcase
    end

    // R1: a period write is visible on the next cycle
    a_r1_period_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && paddr == ADDR_PERIOD) |=> (period == $past(pwdata[CW-1:0])));
endmodule

// File: rtl/pwm_timebase.sv
// Shared period counter: counts from 0 up to the period value, then restarts.
// The restart pulse marks the edge at which buffered channels load.
// Assumes the period may change at any time; a counter above it restarts.
module pwm_timebase #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] period,
    output logic [CW-1:0] cnt,
    output logic          wrap
);
    assign wrap = (cnt >= period);

    // Advance or restart the shared counter.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else if (wrap) cnt <= '0;
        else cnt <= cnt + 1'b1;
    end

    // R2: restart to zero after reaching the period
    a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt == '0));
    // R2: single step otherwise
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/pwm_chan.sv
// One output channel: rising/falling position registers, with an optional
// pending copy (HAS_BUF) and either edge-compare pulse logic or a
// first-order accumulator level output (IS_LEVEL). Readback returns the last
// written value. Assumes wrap marks the edge on which the counter restarts.
module pwm_chan #(
    parameter int CW       = 8,
    parameter bit HAS_BUF  = 1'b1,
    parameter bit IS_LEVEL = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt,
    input  logic          wrap,
    input  logic          sync_en,
    input  logic          on_we,
    input  logic          off_we,
    input  logic [CW-1:0] wdata,
    input  logic          inv,
    output logic          pin,
    output logic [CW-1:0] rb_on,
    output logic [CW-1:0] rb_off
);
    logic [CW-1:0] act_on;
    logic [CW-1:0] act_off;
    logic          state;

    generate
        if (HAS_BUF) begin : g_buf
            logic [CW-1:0] pend_on;
            logic [CW-1:0] pend_off;

            // Pending copy always takes the written value.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pend_on  <= '0;
                    pend_off <= '0;
                end else begin
                    if (on_we)  pend_on  <= wdata;
                    if (off_we) pend_off <= wdata;
                end
            end

            // In-use values: direct write when immediate, else load on restart.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    act_on  <= '0;
                    act_off <= '0;
                end else begin
                    if (on_we && !sync_en) act_on <= wdata;
                    else if (wrap)         act_on <= pend_on;
                    if (off_we && !sync_en) act_off <= wdata;
                    else if (wrap)          act_off <= pend_off;
                end
            end

            assign rb_on  = pend_on;
            assign rb_off = pend_off;

            // R4: pending values move into use on the restart edge
            a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
                (sync_en && wrap) |=> (act_on == $past(pend_on) && act_off == $past(pend_off)));
            // R4: no change in use between restarts in sync mode
            a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
                (sync_en && !wrap) |=> ($stable(act_on) && $stable(act_off)));
            // R5: immediate mode puts the write into use at once
            a_r5_immediate: assert property (@(posedge clk) disable iff (!rst_n)
                (!sync_en && on_we) |=> (act_on == $past(wdata)));
        end else begin : g_direct
            logic unused_mode;
            assign unused_mode = sync_en ^ wrap;

            // Unbuffered: writes go straight into use.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    act_on  <= '0;
                    act_off <= '0;
                end else begin
                    if (on_we)  act_on  <= wdata;
                    if (off_we) act_off <= wdata;
                end
            end

            assign rb_on  = act_on;
            assign rb_off = act_off;

            // R6: unbuffered write is in use on the next cycle
            a_r6_direct: assert property (@(posedge clk) disable iff (!rst_n)
                off_we |=> (act_off == $past(wdata)));
        end

        if (IS_LEVEL) begin : g_level
            logic [CW-1:0] acc;
            logic          unused_pos;
            assign unused_pos = ^{cnt, act_on};

            // Accumulate the level; the carry is the channel state.
            always_ff @(posedge clk) begin
                if (!rst_n) {state, acc} <= '0;
                else        {state, acc} <= {1'b0, acc} + {1'b0, act_off};
            end

            // R8: a zero level never produces a carry
            a_r8_zero_level: assert property (@(posedge clk) disable iff (!rst_n)
                (act_off == '0) |=> !state);
        end else begin : g_pulse
            // Edge compare against the shared counter; falling wins.
            always_ff @(posedge clk) begin
                if (!rst_n)                state <= 1'b0;
                else if (cnt == act_off)   state <= 1'b0;
                else if (cnt == act_on)    state <= 1'b1;
            end

            // R3: falling position clears the state
            a_r3_fall: assert property (@(posedge clk) disable iff (!rst_n)
                (cnt == act_off) |=> !state);
            // R3: no match means hold
            a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
                (cnt != act_off && cnt != act_on) |=> (state == $past(state)));
        end
    endgenerate

    assign pin = state ^ inv;
endmodule

// File: rtl/pwm_bank.sv
// Top of the PWM bank: register slave, shared counter and NCH channels.
// BUF_CH_MASK picks channels with pending copies; LEVEL_CH_MASK picks
// accumulator level outputs. Zero-wait APB; NCH must be a power of two <= 16.
module pwm_bank #(
    parameter int              NCH           = 16,
    parameter int              CW            = 8,
    parameter logic [NCH-1:0]  BUF_CH_MASK   = 16'h00FF,
    parameter logic [NCH-1:0]  LEVEL_CH_MASK = 16'h8000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           psel,
    input  logic           penable,
    input  logic           pwrite,
    input  logic [7:0]     paddr,
    input  logic [31:0]    pwdata,
    output logic [31:0]    prdata,
    output logic           pready,
    output logic [NCH-1:0] pwm_out
);
    localparam int IDXW = $clog2(NCH);

    logic [CW-1:0]   period;
    logic            sync_en;
    logic [NCH-1:0]  inv;
    logic [NCH-1:0]  on_we;
    logic [NCH-1:0]  off_we;
    logic            ch_hit;
    logic [IDXW-1:0] ch_idx;
    logic            ch_field;
    logic [31:0]     glb_rdata;
    logic [CW-1:0]   cnt;
    logic            wrap;
    logic [CW-1:0]   rb_on  [NCH];
    logic [CW-1:0]   rb_off [NCH];

    assign pready = 1'b1;

    pwm_regs #(.NCH(NCH), .CW(CW)) i_regs (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
        .period(period), .sync_en(sync_en), .inv(inv),
        .on_we(on_we), .off_we(off_we), .ch_hit(ch_hit),
        .ch_idx(ch_idx), .ch_field(ch_field), .glb_rdata(glb_rdata)
    );

    pwm_timebase #(.CW(CW)) i_timebase (
        .clk(clk), .rst_n(rst_n), .period(period), .cnt(cnt), .wrap(wrap)
    );

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            pwm_chan #(
                .CW(CW), .HAS_BUF(BUF_CH_MASK[i]), .IS_LEVEL(LEVEL_CH_MASK[i])
            ) i_chan (
                .clk(clk), .rst_n(rst_n), .cnt(cnt), .wrap(wrap),
                .sync_en(sync_en), .on_we(on_we[i]), .off_we(off_we[i]),
                .wdata(pwdata[CW-1:0]), .inv(inv[i]), .pin(pwm_out[i]),
                .rb_on(rb_on[i]), .rb_off(rb_off[i])
            );
        end
    endgenerate

    // Read mux: channel readback overrides the global decode on a hit.
    always_comb begin
        prdata = glb_rdata;
        if (ch_hit)
            prdata = {{(32-CW){1'b0}}, ch_field ? rb_off[ch_idx] : rb_on[ch_idx]};
    end
endmodule

// File: tb/test_pwm_bank.sv
// Self-checking bench: a cycle-accurate reference model built from the
// requirements is compared with every pin on every cycle, plus directed
// checks of readback, duty, inversion, update timing and level averages.
module test_pwm_bank;
    localparam int             NCH  = 16;
    localparam int             CW   = 8;
    localparam logic [15:0]    BUFM = 16'h00FF;
    localparam logic [15:0]    LVLM = 16'h8000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic [15:0] pwm_out;

    int checks = 0;
    int errors = 0;
    bit chk_on = 1'b0;
    bit done = 1'b0;

    pwm_bank #(.NCH(NCH), .CW(CW), .BUF_CH_MASK(BUFM), .LEVEL_CH_MASK(LVLM)) i_pwm_bank (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pwm_out(pwm_out)
    );

    always #5 clk = ~clk;

    // Reference model state
    logic [7:0]  m_period, m_cnt;
    logic        m_sync;
    logic [15:0] m_inv, m_state;
    logic [7:0]  m_aon [16], m_aoff [16], m_pon [16], m_poff [16], m_acc [16];

    always @(posedge clk) begin
        logic       wr, wrap, chw, fld;
        int         ch;
        logic [8:0] sum;
        logic [7:0] wd;
        if (!rst_n) begin
            m_period = 8'hFF; m_cnt = '0; m_sync = 1'b0; m_inv = '0; m_state = '0;
            for (int i = 0; i < 16; i++) begin
                m_aon[i] = '0; m_aoff[i] = '0; m_pon[i] = '0; m_poff[i] = '0; m_acc[i] = '0;
            end
        end else begin
            wr   = psel && penable && pwrite;
            wrap = (m_cnt >= m_period);
            wd   = pwdata[7:0];
            for (int i = 0; i < 16; i++) begin
                if (LVLM[i]) begin
                    sum = {1'b0, m_acc[i]} + {1'b0, m_aoff[i]};
                    m_state[i] = sum[8];
                    m_acc[i] = sum[7:0];
                end else if (m_cnt == m_aoff[i]) m_state[i] = 1'b0;
                else if (m_cnt == m_aon[i])      m_state[i] = 1'b1;
            end
            for (int i = 0; i < 16; i++)
                if (BUFM[i] && wrap) begin m_aon[i] = m_pon[i]; m_aoff[i] = m_poff[i]; end
            chw = wr && paddr >= 8'h40 && paddr < 8'hC0 && paddr[1:0] == 2'b00;
            ch  = int'((paddr - 8'h40) >> 3);
            fld = paddr[2];
            if (chw) begin
                if (BUFM[ch]) begin
                    if (fld) m_poff[ch] = wd; else m_pon[ch] = wd;
                    if (!m_sync) begin if (fld) m_aoff[ch] = wd; else m_aon[ch] = wd; end
                end else begin
                    if (fld) m_aoff[ch] = wd; else m_aon[ch] = wd;
                end
            end
            m_cnt = wrap ? 8'd0 : m_cnt + 8'd1;
            if (wr && paddr == 8'h00) m_period = wd;
            if (wr && paddr == 8'h04) m_sync = pwdata[0];
            if (wr && paddr == 8'h08) m_inv = pwdata[15:0];
        end
    end

    function automatic string tag_of(input int ch);
        if (LVLM[ch])  return "R8";
        if (!BUFM[ch]) return "R6";
        return m_sync ? "R4" : "R5";
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        int ch;
        if (a == 8'h00) return {24'b0, m_period};
        if (a == 8'h04) return {31'b0, m_sync};
        if (a == 8'h08) return {16'b0, m_inv};
        if (a >= 8'h40 && a < 8'hC0 && a[1:0] == 2'b00) begin
            ch = int'((a - 8'h40) >> 3);
            if (BUFM[ch]) return {24'b0, a[2] ? m_poff[ch] : m_pon[ch]};
            return {24'b0, a[2] ? m_aoff[ch] : m_aon[ch]};
        end
        return '0;
    endfunction

    // Per-cycle pin comparison (R3 R7 plus the per-channel update rules)
    always @(negedge clk) begin
        if (chk_on) begin
            checks++;
            if (pwm_out !== (m_state ^ m_inv)) begin
                errors++;
                for (int i = 0; i < 16; i++)
                    if (pwm_out[i] !== (m_state[i] ^ m_inv[i])) begin
                        $display("FAIL %s/R3/R7 ch%0d pin actual %b expected %b at %0t",
                                 tag_of(i), i, pwm_out[i], m_state[i] ^ m_inv[i], $time);
                        break;
                    end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic apb_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk); penable = 1'b1;
        @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge clk); penable = 1'b1;
        #2 d = prdata;
        @(negedge clk); psel = 1'b0; penable = 1'b0;
    endtask

    task automatic read_chk(input logic [7:0] a, input string tag);
        logic [31:0] d, e;
        apb_read(a, d);
        e = exp_read(a);
        chk(d == e, tag, d, e);
    endtask

    task automatic count_high(input int ch, input int n, output int hits);
        hits = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (pwm_out[ch]) hits++;
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual running expected finished");
            finish_run();
        end
    end

    initial begin
        int hits;
        int rem;
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_on = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk(pwm_out == 16'h0, "R9 pins after reset", pwm_out, 0);
        read_chk(8'h00, "R9 period reset");
        read_chk(8'h04, "R9 control reset");
        read_chk(8'h44, "R9 position reset");
        chk(pready == 1'b1, "R1 pready", pready, 1);
        read_chk(8'h0C, "R1 unmapped read");

        // R2 R3: period 3, ch2 rises at 0 falls at 3 -> high 3 of 4
        apb_write(8'h00, 32'd3);
        read_chk(8'h00, "R1 period readback");
        apb_write(8'h50, 32'd0);
        apb_write(8'h54, 32'd3);
        repeat (8) @(negedge clk);
        count_high(2, 40, hits);
        chk(hits == 30, "R2/R3 duty count ch2", hits, 30);
        // R7: invert ch2
        apb_write(8'h08, 32'h0004);
        repeat (2) @(negedge clk);
        count_high(2, 40, hits);
        chk(hits == 10, "R7 inverted count ch2", hits, 10);
        apb_write(8'h08, 32'h0000);

        // R4: sync write just after restart has no effect before next restart
        apb_write(8'h00, 32'd255);
        apb_write(8'h04, 32'd1);
        while (m_cnt != 8'd0) @(negedge clk);
        apb_write(8'h40, 32'd5);
        apb_write(8'h44, 32'd250);
        read_chk(8'h40, "R1 pending readback ch0");
        rem = int'(m_period) - int'(m_cnt);
        count_high(0, rem, hits);
        chk(hits == 0, "R4 no early update ch0", hits, 0);
        count_high(0, 256, hits);
        chk(hits == 245, "R4 after restart ch0", hits, 245);

        // R6: unbuffered ch8 updates at once even in sync mode
        while (m_cnt != 8'd0) @(negedge clk);
        apb_write(8'h80, 32'd5);
        apb_write(8'h84, 32'd250);
        count_high(8, 20, hits);
        chk(hits > 0, "R6 immediate ch8", hits, 1);

        // R5: buffered ch1 in immediate mode
        apb_write(8'h04, 32'd0);
        while (m_cnt != 8'd0) @(negedge clk);
        apb_write(8'h48, 32'd5);
        apb_write(8'h4C, 32'd250);
        count_high(1, 20, hits);
        chk(hits > 0, "R5 immediate ch1", hits, 1);

        // R8: level channel 15 averages
        apb_write(8'hBC, 32'd64);
        repeat (2) @(negedge clk);
        count_high(15, 256, hits);
        chk(hits == 64, "R8 level 64", hits, 64);
        apb_write(8'hBC, 32'd200);
        repeat (2) @(negedge clk);
        count_high(15, 256, hits);
        chk(hits == 200, "R8 level 200", hits, 200);
        apb_write(8'hBC, 32'd0);
        repeat (2) @(negedge clk);
        count_high(15, 256, hits);
        chk(hits == 0, "R8 level 0", hits, 0);

        // Random phase: model compares every pin every cycle
        for (int n = 0; n < 500; n++) begin
            int k;
            k = int'($urandom_range(0, 99));
            if (k < 55) begin
                apb_write(8'h40 + 8'(($urandom_range(0, 15)) * 8) + 8'(($urandom_range(0, 1)) * 4),
                          32'($urandom_range(0, 63)));
            end else if (k < 65) begin
                apb_write(8'h00, 32'($urandom_range(4, 60)));
            end else if (k < 75) begin
                apb_write(8'h04, 32'($urandom_range(0, 1)));
            end else if (k < 82) begin
                apb_write(8'h08, 32'($urandom_range(0, 65535)));
            end else if (k < 92) begin
                read_chk(8'h40 + 8'(($urandom_range(0, 15)) * 8) + 8'(($urandom_range(0, 1)) * 4),
                         "R1 random readback");
            end else begin
                repeat ($urandom_range(1, 40)) @(negedge clk);
            end
        end
        repeat (80) @(negedge clk);
        for (int c = 0; c < 16; c++) begin
            read_chk(8'h40 + 8'(c * 8), "R1 final rising readback");
            read_chk(8'h44 + 8'(c * 8), "R1 final falling readback");
        end
        done = 1'b1;
        chk_on = 1'b0;
        finish_run();
    end
endmodule